// File: doc/BRIEF.md
# Serial Descriptor Word Fetcher

This block returns one 16-bit descriptor word for each word-address request. A strap input picks the source of the word. With the strap high, the block runs a three-wire serial read cycle to an external EEPROM organised in 16-bit words. With the strap low, it looks the word up in an internal ROM and leaves every bus pin floating.

In serial mode the block drives the chip select, the serial clock and the command/address line. It receives the data on a separate input. The serial clock is the system clock divided by the parameter `DIV`. A second strap selects the address width: narrow for the smallest EEPROM size, wide for the two larger sizes. A pulse on `reqStart` while the block is idle starts a fetch. Completion is reported by a one-cycle pulse on `reqDone`, and `rdData` holds the word from that pulse until the next completion.

Both straps are assumed static while a fetch is in progress. The internal ROM content is a computed placeholder: the word for address `a` is `{a ^ 8'h5A, ~a}`.

Top module: `eeprom_word_fetch`

## Requirements
- R1: With `extEnable` low, a start taken in idle gives `reqDone` one clock after the start edge, and `rdData = {reqAddr ^ 8'h5A, ~reqAddr}`.
- R2: With `extEnable` low, `csOe`, `skOe` and `cmdOe` are all 0. With `extEnable` high, all three are 1.
- R3: In a serial read, the first three bits on `cmdOut`, taken on the first three rising edges of `skOut`, are 1, 1, 0, and `csOut` is high for the whole cycle.
- R4: After those three bits, the address is sent MSB first: `reqAddr[5:0]` when `sizeSel` is 0 (upper address bits ignored), and `reqAddr[7:0]` when `sizeSel` is 1.
- R5: After the last address bit, one dummy bit period is skipped. Then 16 bits are sampled from `dinIn` on `skOut` rising edges, MSB first, and returned on `rdData`.
- R6: `skOut` has a period of `DIV` clocks and is high for the second half of each bit. A serial read with A address bits raises `reqDone` (21+A)·`DIV` clocks after the start edge.
- R7: `csOut` stays low for at least `DIV` clocks between consecutive reads. While idle with `extEnable` high, `csOut` and `skOut` are driven low.
- R8: A `reqStart` that arrives while a fetch is in progress is ignored, and the running fetch returns its own word.
- R9: `reqDone` is low in reset and is never high for two cycles in a row.
- R10: `skOut` is high only while `csOut` is high, and `cmdOut` changes only while `skOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| reqStart | input | 1 | Start a fetch (taken when idle) |
| reqAddr | input | 8 | Word address |
| reqDone | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Fetched word |
| extEnable | input | 1 | Strap: 1 = external EEPROM, 0 = internal ROM |
| sizeSel | input | 1 | Strap: 0 = 6-bit address, 1 = 8-bit address |
| csOut | output | 1 | Chip select level |
| csOe | output | 1 | Chip select output enable |
| skOut | output | 1 | Serial clock level |
| skOe | output | 1 | Serial clock output enable |
| cmdOut | output | 1 | Command/address serial output |
| cmdOe | output | 1 | Command/address output enable |
| dinIn | input | 1 | Serial data from the EEPROM |

## Verification
A wrong internal state shows up at the pins within the same fetch. A bad bit or slot counter corrupts the start bits or address bits that the bench's EEPROM model decodes. A bad counter also moves the `reqDone` cycle away from its exact arithmetic latency. A wrong sample phase shifts the returned word by one bit, which every swept address shows. A state machine that misses the gap or the busy lock shows up either as a short chip-select low time or as a word for the wrong address on the next completion.

// File: rtl/ewf_pkg.sv
package ewf_pkg;
  localparam int ADDR_W_SMALL = 6;
  localparam int ADDR_W_LARGE = 8;
  localparam int DATA_W       = 16;
  localparam int HDR_W        = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP, ST_FIN} ewfState_t;

  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic sampleRx;
    logic loadRom;
    logic loadRx;
  } ewfStrobe_t;

  function automatic logic [DATA_W-1:0] romWord(input logic [ADDR_W_LARGE-1:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction
endpackage

// File: rtl/ewf_ctrl.sv
module ewf_ctrl
  import ewf_pkg::*;
#(
  parameter int DIV = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqStart,
  input  logic       extEnable,
  input  logic       sizeSel,
  output ewfStrobe_t strb,
  output logic       csAct,
  output logic       skAct,
  output logic       doneQ,
  output logic       busy
);
  localparam int HALF        = DIV / 2;
  localparam int CNT_W       = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int SLOTS_SMALL = HDR_W + ADDR_W_SMALL + 1 + DATA_W;
  localparam int SLOTS_LARGE = HDR_W + ADDR_W_LARGE + 1 + DATA_W;
  localparam int SLOT_W      = $clog2(SLOTS_LARGE + 1);

  ewfState_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] lastSlot;
  logic              cntEnd;

  assign cntEnd = (cnt == CNT_W'(DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      slot     <= '0;
      lastSlot <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqStart) begin
            cnt  <= '0;
            slot <= '0;
            if (extEnable) begin
              state    <= ST_SHIFT;
              lastSlot <= sizeSel ? SLOT_W'(SLOTS_LARGE - 1) : SLOT_W'(SLOTS_SMALL - 1);
            end else begin
              state <= ST_FIN;
            end
          end
        end
        ST_SHIFT: begin
          if (cntEnd) begin
            cnt <= '0;
            if (slot == lastSlot) state <= ST_GAP;
            else slot <= slot + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (cntEnd) begin
            cnt   <= '0;
            state <= ST_FIN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.loadTx   = (state == ST_IDLE) && reqStart && extEnable;
    strb.loadRom  = (state == ST_IDLE) && reqStart && !extEnable;
    strb.shiftTx  = (state == ST_SHIFT) && cntEnd;
    strb.sampleRx = (state == ST_SHIFT) && (cnt == CNT_W'(HALF));
    strb.loadRx   = (state == ST_GAP) && cntEnd;
  end

  assign csAct = (state == ST_SHIFT);
  assign skAct = (state == ST_SHIFT) && (cnt >= CNT_W'(HALF));
  assign doneQ = (state == ST_FIN);
  assign busy  = (state != ST_IDLE);
endmodule

// File: rtl/ewf_datapath.sv
module ewf_datapath
  import ewf_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  ewfStrobe_t              strb,
  input  logic [ADDR_W_LARGE-1:0] reqAddr,
  input  logic                    sizeSel,
  input  logic                    dinIn,
  output logic                    cmdBit,
  output logic [DATA_W-1:0]       rdData
);
  localparam int TX_W = HDR_W + ADDR_W_LARGE;
  localparam int PAD  = ADDR_W_LARGE - ADDR_W_SMALL;
  localparam logic [HDR_W-1:0] HDR = 3'b110;

  logic [TX_W-1:0]   txSh;
  logic [TX_W-1:0]   txSmall;
  logic [DATA_W-1:0] rxSh;

  generate
    if (PAD > 0) begin : g_pad
      assign txSmall = {HDR, reqAddr[ADDR_W_SMALL-1:0], {PAD{1'b0}}};
    end else begin : g_nopad
      assign txSmall = {HDR, reqAddr[ADDR_W_SMALL-1:0]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh   <= '0;
      rxSh   <= '0;
      rdData <= '0;
    end else begin
      if (strb.loadTx)       txSh <= sizeSel ? {HDR, reqAddr} : txSmall;
      else if (strb.shiftTx) txSh <= {txSh[TX_W-2:0], 1'b0};
      if (strb.sampleRx)     rxSh <= {rxSh[DATA_W-2:0], dinIn};
      if (strb.loadRom)      rdData <= romWord(reqAddr);
      else if (strb.loadRx)  rdData <= rxSh;
    end
  end

  assign cmdBit = txSh[TX_W-1];
endmodule

// File: rtl/eeprom_word_fetch.sv
module eeprom_word_fetch
  import ewf_pkg::*;
#(
  parameter int DIV = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqStart,
  input  logic [ADDR_W_LARGE-1:0] reqAddr,
  output logic                    reqDone,
  output logic [DATA_W-1:0]       rdData,
  input  logic                    extEnable,
  input  logic                    sizeSel,
  output logic                    csOut,
  output logic                    csOe,
  output logic                    skOut,
  output logic                    skOe,
  output logic                    cmdOut,
  output logic                    cmdOe,
  input  logic                    dinIn
);
  ewfStrobe_t strb;
  logic csAct, skAct, cmdBit, busy;

  ewf_ctrl #(.DIV(DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .extEnable(extEnable),
    .sizeSel(sizeSel), .strb(strb), .csAct(csAct), .skAct(skAct),
    .doneQ(reqDone), .busy(busy)
  );

  ewf_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .sizeSel(sizeSel),
    .dinIn(dinIn), .cmdBit(cmdBit), .rdData(rdData)
  );

  assign csOut  = csAct;
  assign skOut  = skAct;
  assign cmdOut = csAct & cmdBit;
  assign csOe   = extEnable;
  assign skOe   = extEnable;
  assign cmdOe  = extEnable;
endmodule

// File: rtl/ewf_checker.sv
module ewf_checker #(
  parameter int DIV = 16
) (
  input logic clk,
  input logic rstN,
  input logic reqStart,
  input logic extEnable,
  input logic busy,
  input logic reqDone,
  input logic csOut,
  input logic csOe,
  input logic skOut,
  input logic skOe,
  input logic cmdOut,
  input logic cmdOe
);
  localparam int LW = $clog2(DIV + 1);
  logic [LW-1:0] lowCnt;
  logic          seenCs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
      seenCs <= 1'b0;
    end else begin
      seenCs <= seenCs | csOut;
      if (csOut) lowCnt <= '0;
      else if (lowCnt < LW'(DIV)) lowCnt <= lowCnt + 1'b1;
    end
  end

  p_rom_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqStart && !extEnable && !busy) |=> reqDone);
  p_float_r2: assert property (@(posedge clk) disable iff (!rstN)
    !extEnable |-> (!csOe && !skOe && !cmdOe));
  p_cs_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csOut) |-> (!seenCs || lowCnt >= LW'(DIV)));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone);
  p_sk_in_cs_r10: assert property (@(posedge clk) disable iff (!rstN)
    skOut |-> csOut);
  p_cmd_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cmdOut) |-> !skOut);
endmodule

bind eeprom_word_fetch ewf_checker #(.DIV(DIV)) u_chk (
  .clk(clk), .rstN(rstN), .reqStart(reqStart), .extEnable(extEnable),
  .busy(busy), .reqDone(reqDone), .csOut(csOut), .csOe(csOe),
  .skOut(skOut), .skOe(skOe), .cmdOut(cmdOut), .cmdOe(cmdOe)
);

// File: tb/sim_eeprom_word_fetch.sv
module sim_eeprom_word_fetch;
  localparam int DIV = 8;

  logic clk = 1'b0, rstN = 1'b0, reqStart = 1'b0, extEnable = 1'b0, sizeSel = 1'b0;
  logic [7:0] reqAddr = '0;
  logic reqDone, csOut, csOe, skOut, skOe, cmdOut, cmdOe, dinIn;
  logic [15:0] rdData;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  eeprom_word_fetch #(.DIV(DIV)) u0 (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqAddr(reqAddr),
    .reqDone(reqDone), .rdData(rdData), .extEnable(extEnable), .sizeSel(sizeSel),
    .csOut(csOut), .csOe(csOe), .skOut(skOut), .skOe(skOe),
    .cmdOut(cmdOut), .cmdOe(cmdOe), .dinIn(dinIn)
  );

  function automatic logic [15:0] memWord(input logic [7:0] a);
    return (16'(a) * 16'h0101) ^ 16'h3C5A;
  endfunction

  // EEPROM model
  int k = 0;
  int aw;
  logic [7:0] capAddr = '0;
  logic [2:0] hdr = '0;
  assign aw = sizeSel ? 8 : 6;

  function automatic logic modelBit(input int kk, input logic [7:0] a, input int w, input logic cs);
    logic [15:0] word;
    word = memWord(a);
    if (cs && kk >= 4 + w && kk < 20 + w) return word[19 + w - kk];
    return 1'b0;
  endfunction

  assign dinIn = modelBit(k, capAddr, aw, csOut);

  always @(posedge csOut) begin k = 0; capAddr = '0; hdr = '0; end
  always @(posedge skOut) begin
    if (k < 3) hdr = {hdr[1:0], cmdOut};
    else if (k < 3 + aw) capAddr = {capAddr[6:0], cmdOut};
  end
  always @(negedge skOut) k = k + 1;

  // pin monitors
  int lowRun = 0, skHigh = 0, viol = 0;
  logic prevCmd = 1'b0;
  always @(negedge clk) begin
    lowRun = csOut ? 0 : lowRun + 1;
    if (skOut) skHigh++;
    if (skOut && !csOut) viol++;
    if (rstN && cmdOut != prevCmd && skOut) viol++;
    prevCmd = cmdOut;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic doRead(input logic [7:0] a, input bit interfere, output int n, output logic [15:0] d);
    @(posedge clk); #1 reqStart = 1'b1; reqAddr = a;
    @(posedge clk); #1 reqStart = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (interfere && n == 50) begin reqStart = 1'b1; reqAddr = ~a; end
      if (interfere && n == 51) reqStart = 1'b0;
    end while (!reqDone && n < 5000);
    d = rdData;
    @(negedge clk);
    chk(!reqDone, "R9", "done width", int'(reqDone), 0);
  endtask

  initial begin
    #(200000 * 10);
    chk(1'b0, "WDOG", "timeout", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] d;
    repeat (3) @(negedge clk);
    chk(!reqDone, "R9", "reset done", int'(reqDone), 0);
    chk(!csOut && !skOut, "R7", "reset pins", int'({csOut, skOut}), 0);
    #1 rstN = 1'b1;

    // R1/R2: internal ROM sweep
    for (int a = 0; a < 256; a++) begin
      doRead(8'(a), 1'b0, n, d);
      chk(n == 1, "R1", "rom latency", n, 1);
      chk(d == {8'(a) ^ 8'h5A, ~8'(a)}, "R1", "rom word", d, {8'(a) ^ 8'h5A, ~8'(a)});
      chk({csOe, skOe, cmdOe} == 3'b000, "R2", "float", int'({csOe, skOe, cmdOe}), 0);
    end

    // serial sweeps, both sizes
    extEnable = 1'b1;
    for (int s = 0; s < 2; s++) begin
      int w;
      sizeSel = s[0];
      w = s ? 8 : 6;
      @(negedge clk);
      chk({csOe, skOe, cmdOe} == 3'b111, "R2", "drive", int'({csOe, skOe, cmdOe}), 7);
      chk(!csOut && !skOut, "R7", "idle low", int'({csOut, skOut}), 0);
      for (int a = 0; a < (1 << w); a++) begin
        logic [7:0] sendA;
        sendA = s ? 8'(a) : (8'(a) | 8'hC0);
        skHigh = 0;
        doRead(sendA, 1'b0, n, d);
        chk(hdr == 3'b110, "R3", "header", hdr, 3'b110);
        chk(capAddr == 8'(a), "R4", "address", capAddr, a);
        chk(d == memWord(8'(a)), "R5", "data", d, memWord(8'(a)));
        chk(n == (21 + w) * DIV + 1, "R6", "latency", n, (21 + w) * DIV + 1);
        chk(lowRun >= DIV, "R7", "cs gap", lowRun, DIV);
        if (a == 5) chk(skHigh == (20 + w) * DIV / 2, "R6", "sk high cycles", skHigh, (20 + w) * DIV / 2);
      end
    end

    // R8: start while busy ignored
    doRead(8'h21, 1'b1, n, d);
    chk(d == memWord(8'h21), "R8", "busy data", d, memWord(8'h21));
    chk(capAddr == 8'h21, "R8", "busy addr", capAddr, 8'h21);
    repeat (4 * DIV) begin
      @(negedge clk);
      if (reqDone || csOut) chk(1'b0, "R8", "extra fetch", int'({reqDone, csOut}), 0);
    end
    chk(viol == 0, "R10", "sk/cmd rule", viol, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule